// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight interrupt request lines, each masked by an 8-bit mask word. It keeps a record of which levels the processor is currently servicing and raises one interrupt output when a request should reach the processor. Line 0 has the highest priority. The processor answers with two acknowledge strobes. The first strobe freezes the winning line and marks it as in service. The second strobe returns an 8-bit vector. Once a handler finishes, it sends a non-specific end-of-interrupt strobe, which retires the most urgent level still in service.

All configuration arrives on plain input ports. These carry the upper bits of the vector, automatic end-of-interrupt, special mask operation, special nesting for lines that feed a downstream controller, and a map of which lines are such cascade lines. Requests are edge latched. When a latched request goes away before the first acknowledge strobe, the block answers with a default vector for the lowest level and records nothing as in service.

Top module: `nest_irq_ctrl`

## Requirements
- R1: When several unmasked, eligible requests are pending at the first acknowledge strobe, the lowest-numbered line wins.
- R2: One cycle after the second acknowledge strobe, `vec_valid_o` pulses for exactly one cycle. At the same time `vec_o` carries `vec_base_i` in bits 7:3 and the winning line number in bits 2:0.
- R3: The first acknowledge strobe sets the winner's bit in `isr_o` (bit n for line n) and clears that line's bit in `irr_o`.
- R4: Outside special mask operation, a set in-service bit blocks requests at its own level and at lower priority, so `int_o` stays low for them. A request of strictly higher priority still raises `int_o`.
- R5: An end-of-interrupt strobe clears only the lowest-numbered set bit of `isr_o`.
- R6: With `aeoi_i` high, the winner's in-service bit is cleared by the second acknowledge strobe, so no end-of-interrupt strobe is needed.
- R7: When a request drops before the first acknowledge strobe and no other request is eligible, the vector carries line 7 and `isr_o` is left unchanged.
- R8: With `smm_i` high, in-service bits block nothing, and any unmasked pending request raises `int_o`.
- R9: With `sfnm_i` high, a line marked in `cascade_map_i` that is already in service can raise `int_o` again on a new rising edge.
- R10: A line whose `mask_i` bit is 1 never raises `int_o` and is never chosen. It stays visible in `irr_o`.
- R11: A request is latched into `irr_o` only on a rising edge of its line. It clears when the line goes low. A line held high after it has been acknowledged does not request again.
- R12: After reset, `isr_o`, `irr_o`, `int_o` and `vec_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 8 | Request lines, bit n is line n |
| mask_i | input | 8 | Per-line mask, 1 blocks the line |
| vec_base_i | input | 5 | Upper five bits of the returned vector |
| aeoi_i | input | 1 | Automatic end-of-interrupt at the second strobe |
| sfnm_i | input | 1 | Special nesting for cascade lines |
| smm_i | input | 1 | Special mask operation, in-service bits stop blocking |
| cascade_map_i | input | 8 | Lines that feed a downstream controller |
| ack_i | input | 1 | Acknowledge strobe, one cycle per pulse |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector from the last completed acknowledge |
| vec_valid_o | output | 1 | One-cycle pulse when `vec_o` is fresh |
| isr_o | output | 8 | In-service register |
| irr_o | output | 8 | Latched pending requests |

## Verification
The bench goes after the nesting ceiling. A design that compares with less-or-equal instead of strictly-less would let a same-level request raise `int_o`, and the check on that output would catch it. It also drops a line between its latch and the first strobe. A design that took its choice from stale latched state would return the dropped line's vector or leave a stray in-service bit, rather than returning line 7. End-of-interrupt strobes are issued with two levels in service, both in nested and in special mask operation. A design that cleared the most recent or the highest-numbered level would leave the wrong bit in `isr_o`. The bench also checks special nesting on a cascade line and a level held high after acknowledge. These catch a design that refuses the re-request, or one that re-latches on level rather than on an edge.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_VEC  = 1'b1
  } ack_phase_e;
endpackage

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o,
  output logic [N-1:0] live_o
);
  logic [N-1:0] prev_q, irr_q, irr_d;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_comb begin
      irr_d[g] = (irr_q[g] | (irq_i[g] & ~prev_q[g])) & irq_i[g] & ~clr_i[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_q  <= irr_d;
    end
  end

  assign irr_o  = irr_q;
  assign live_o = irr_q & irq_i;

  // R11: a latched bit implies the line was high on the previous edge
  p_irr_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q & ~$past(irq_i)) == '0);
endmodule

// File: rtl/nic_resolver.sv
module nic_resolver #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  isr_i,
  input  logic [N-1:0]  casc_i,
  input  logic          smm_i,
  input  logic          sfnm_i,
  output logic          win_valid_o,
  output logic [LW-1:0] win_idx_o
);
  logic [N-1:0]  elig, allow;
  logic [LW-1:0] ceil_idx;
  logic          has_isr;

  always_comb begin
    has_isr  = |isr_i;
    ceil_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (isr_i[i]) ceil_idx = LW'(i);
    end
    elig = req_i & ~mask_i;
    for (int i = 0; i < N; i++) begin
      if (smm_i || !has_isr || i < int'(ceil_idx)) allow[i] = elig[i];
      else if (sfnm_i && casc_i[i] && i == int'(ceil_idx)) allow[i] = elig[i];
      else allow[i] = 1'b0;
    end
    win_valid_o = |allow;
    win_idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (allow[i]) win_idx_o = LW'(i);
    end
  end

  logic [N-1:0] at_or_above;
  always_comb begin
    for (int i = 0; i < N; i++) at_or_above[i] = (i <= int'(win_idx_o));
  end

  // R4: plain nesting never picks a line at or below an in-service level
  p_nest_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!smm_i && !sfnm_i && win_valid_o) |-> ((isr_i & at_or_above) == '0));
  // R10: the winner is an unmasked pending line
  p_win_unmasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (!mask_i[win_idx_o] && req_i[win_idx_o]));
endmodule

// File: rtl/nic_service.sv
module nic_service
  import nic_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N),
  parameter int VW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_i,
  input  logic            eoi_i,
  input  logic            aeoi_i,
  input  logic [VW-LW-1:0] base_i,
  input  logic            win_valid_i,
  input  logic [LW-1:0]   win_idx_i,
  output logic [N-1:0]    isr_o,
  output logic [N-1:0]    clr_o,
  output logic            busy_o,
  output logic [VW-1:0]   vec_o,
  output logic            vec_valid_o
);
  localparam logic [LW-1:0] PHANTOM = LW'(N - 1);

  ack_phase_e    ph_q, ph_d;
  logic [LW-1:0] sel_q, sel_d;
  logic          phantom_q, phantom_d;
  logic [N-1:0]  isr_q, isr_d, set_v, drop_v, eoi_hit;
  logic [VW-1:0] vec_q, vec_d;
  logic          vld_q, vld_d;

  always_comb begin
    ph_d      = ph_q;
    sel_d     = sel_q;
    phantom_d = phantom_q;
    vec_d     = vec_q;
    vld_d     = 1'b0;
    set_v     = '0;
    drop_v    = '0;
    clr_o     = '0;
    eoi_hit   = isr_q & (~isr_q + 1'b1);
    if (ack_i && ph_q == PH_IDLE) begin
      ph_d = PH_VEC;
      if (win_valid_i) begin
        sel_d            = win_idx_i;
        phantom_d        = 1'b0;
        set_v[win_idx_i] = 1'b1;
        clr_o[win_idx_i] = 1'b1;
      end else begin
        sel_d     = PHANTOM;
        phantom_d = 1'b1;
      end
    end else if (ack_i && ph_q == PH_VEC) begin
      ph_d  = PH_IDLE;
      vec_d = {base_i, sel_q};
      vld_d = 1'b1;
      if (aeoi_i && !phantom_q) drop_v[sel_q] = 1'b1;
    end
    if (eoi_i) drop_v = drop_v | eoi_hit;
    isr_d = (isr_q & ~drop_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      sel_q     <= '0;
      phantom_q <= 1'b0;
      isr_q     <= '0;
      vec_q     <= '0;
      vld_q     <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      sel_q     <= sel_d;
      phantom_q <= phantom_d;
      isr_q     <= isr_d;
      vec_q     <= vec_d;
      vld_q     <= vld_d;
    end
  end

  assign isr_o       = isr_q;
  assign busy_o      = (ph_q == PH_VEC);
  assign vec_o       = vec_q;
  assign vec_valid_o = vld_q;

  // R3: first strobe marks the winner in service
  p_set_isr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ph_q == PH_IDLE && win_valid_i) |=> isr_q[$past(win_idx_i)]);
  // R7: phantom acknowledge leaves the in-service record alone
  p_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ph_q == PH_IDLE && !win_valid_i && !eoi_i) |=> isr_q == $past(isr_q));
  // R2: vector layout after second strobe
  p_vec_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ph_q == PH_VEC) |=> (vld_q && vec_q == {$past(base_i), $past(sel_q)}));
  // R2: valid is a single-cycle pulse
  p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R5: one end-of-interrupt retires exactly one level
  p_eoi_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
  // R6: automatic retirement at the second strobe
  p_aeoi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ph_q == PH_VEC && aeoi_i && !phantom_q) |=> !isr_q[$past(sel_q)]);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N  = 8,
  parameter int VW = 8,
  parameter int LW = $clog2(N),
  parameter int BW = VW - LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_i,
  input  logic [N-1:0]  mask_i,
  input  logic [BW-1:0] vec_base_i,
  input  logic          aeoi_i,
  input  logic          sfnm_i,
  input  logic          smm_i,
  input  logic [N-1:0]  cascade_map_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic          int_o,
  output logic [VW-1:0] vec_o,
  output logic          vec_valid_o,
  output logic [N-1:0]  isr_o,
  output logic [N-1:0]  irr_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [N-1:0]  clr_v, live_v, isr_v;
  logic          win_valid, busy;
  logic [LW-1:0] win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nic_req_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_int_n), .irq_i(irq_i), .clr_i(clr_v),
    .irr_o(irr_o), .live_o(live_v)
  );

  nic_resolver #(.N(N), .LW(LW)) u_resolve (
    .clk(clk), .rst_n(rst_int_n), .req_i(live_v), .mask_i(mask_i),
    .isr_i(isr_v), .casc_i(cascade_map_i), .smm_i(smm_i), .sfnm_i(sfnm_i),
    .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  nic_service #(.N(N), .LW(LW), .VW(VW)) u_service (
    .clk(clk), .rst_n(rst_int_n), .ack_i(ack_i), .eoi_i(eoi_i),
    .aeoi_i(aeoi_i), .base_i(vec_base_i), .win_valid_i(win_valid),
    .win_idx_i(win_idx), .isr_o(isr_v), .clr_o(clr_v), .busy_o(busy),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  assign isr_o = isr_v;
  assign int_o = win_valid && !busy;

  // R10: a masked line alone never raises the interrupt output
  p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((live_v & ~mask_i) == '0) |-> !int_o);
endmodule

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq, mask, casc;
  logic [4:0] base;
  logic       aeoi, sfnm, smm, ack, eoi;
  logic       int_o, vec_valid;
  logic [7:0] vec, isr, irr;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .mask_i(mask), .vec_base_i(base),
    .aeoi_i(aeoi), .sfnm_i(sfnm), .smm_i(smm), .cascade_map_i(casc),
    .ack_i(ack), .eoi_i(eoi), .int_o(int_o), .vec_o(vec),
    .vec_valid_o(vec_valid), .isr_o(isr), .irr_o(irr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected vectors as the design presents them
  always @(negedge clk) begin
    if (rst_n && vec_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected vector actual=%h expected=none", vec);
      end else begin
        chk("R2 vector", {24'd0, vec}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic ack_seq(input logic [2:0] line);
    exp_q.push_back({base, line});
    ack = 1'b1; @(negedge clk); ack = 1'b0; @(negedge clk);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic send_eoi();
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = '0; mask = '0; casc = '0; base = 5'b00100;
    aeoi = 0; sfnm = 0; smm = 0; ack = 0; eoi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 isr", {24'd0, isr}, 0);
    chk("R12 irr", {24'd0, irr}, 0);
    chk("R12 int", {31'd0, int_o}, 0);
    chk("R12 valid", {31'd0, vec_valid}, 0);

    // R1 / R3 / R4 / R5 nesting
    irq[5] = 1; irq[2] = 1; @(negedge clk);
    chk("R11 latch", {24'd0, irr}, 32'h24);
    chk("R1 int", {31'd0, int_o}, 1);
    ack_seq(3'd2); @(negedge clk);
    chk("R3 isr", {24'd0, isr}, 32'h04);
    chk("R3 irr", {24'd0, irr}, 32'h20);
    chk("R4 lower held", {31'd0, int_o}, 0);
    irq[1] = 1; @(negedge clk);
    chk("R4 higher passes", {31'd0, int_o}, 1);
    ack_seq(3'd1); @(negedge clk);
    chk("R3 isr nested", {24'd0, isr}, 32'h06);
    send_eoi(); @(negedge clk);
    chk("R5 eoi highest", {24'd0, isr}, 32'h04);
    send_eoi(); @(negedge clk);
    chk("R5 eoi empty", {24'd0, isr}, 0);
    chk("R4 released", {31'd0, int_o}, 1);
    ack_seq(3'd5); send_eoi();
    irq = '0; @(negedge clk); @(negedge clk);
    chk("R11 cleared", {24'd0, irr}, 0);

    // R11 held level does not re-request
    irq[3] = 1; @(negedge clk);
    ack_seq(3'd3); send_eoi(); @(negedge clk);
    chk("R11 held irr", {24'd0, irr}, 0);
    chk("R11 held int", {31'd0, int_o}, 0);
    irq = '0; @(negedge clk);

    // R10 mask
    mask = 8'h10; irq[4] = 1; @(negedge clk);
    chk("R10 irr visible", {24'd0, irr}, 32'h10);
    chk("R10 int blocked", {31'd0, int_o}, 0);
    mask = '0; @(negedge clk);
    chk("R10 unmasked", {31'd0, int_o}, 1);
    ack_seq(3'd4); send_eoi();
    irq = '0; @(negedge clk);

    // R7 phantom
    irq[6] = 1; @(negedge clk);
    irq[6] = 0; @(negedge clk);
    chk("R7 irr dropped", {24'd0, irr}, 0);
    ack_seq(3'd7); @(negedge clk);
    chk("R7 isr untouched", {24'd0, isr}, 0);

    // R6 automatic end-of-interrupt
    aeoi = 1; irq[2] = 1; @(negedge clk);
    ack_seq(3'd2);
    chk("R6 isr auto", {24'd0, isr}, 0);
    aeoi = 0; irq = '0; @(negedge clk);

    // R8 special mask
    irq[1] = 1; @(negedge clk);
    ack_seq(3'd1); @(negedge clk);
    irq[6] = 1; @(negedge clk);
    chk("R4 lower held smm off", {31'd0, int_o}, 0);
    smm = 1; @(negedge clk);
    chk("R8 smm passes", {31'd0, int_o}, 1);
    ack_seq(3'd6); @(negedge clk);
    chk("R8 isr two", {24'd0, isr}, 32'h42);
    send_eoi(); @(negedge clk);
    chk("R5 eoi in smm", {24'd0, isr}, 32'h40);
    send_eoi(); smm = 0; irq = '0; @(negedge clk);

    // R9 special nesting on a cascade line
    casc = 8'h04; irq[2] = 1; @(negedge clk);
    ack_seq(3'd2); @(negedge clk);
    irq[2] = 0; @(negedge clk);
    irq[2] = 1; @(negedge clk);
    chk("R9 same level held", {31'd0, int_o}, 0);
    sfnm = 1; @(negedge clk);
    chk("R9 cascade re-request", {31'd0, int_o}, 1);
    ack_seq(3'd2); @(negedge clk);
    chk("R9 isr", {24'd0, isr}, 32'h04);
    send_eoi(); @(negedge clk);
    chk("R9 isr cleared", {24'd0, isr}, 0);

    @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule